// File: doc/BRIEF.md
# Double-Buffered PWM Timer

This block is a 16-bit up-counting timer that drives a pulse-width-modulated output. Two compare values shape the waveform: a period value sets how far the counter runs before it wraps to zero, and a width value sets how many count ticks the output stays active after each wrap. Software writes both values through simple write ports at any time. Each value first lands in a host-side register and moves into a shadow buffer only when the counter wraps, so the running waveform never shows a half-updated period.

The counter moves only on system clocks where the count-tick enable is high. While the run input is low the counter parks at all-ones and every output is inactive. The first tick after run rises takes the counter to zero and loads both buffers from the host registers, so the values written beforehand govern the first period. A toggle output flips at every wrap, which gives a square wave at half the PWM rate. Two one-clock interrupt pulses mark the wrap and the width match.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: After reset every output (pwm_o, half_rate_o, wrap_irq_o, width_irq_o) is 0, and both host compare registers hold 0.
- R2: With the period buffer at P, one PWM period lasts P+1 count ticks: the counter runs 0 to P and the tick after the one that reaches P clears it to 0.
- R3: With width buffer W and 0 < W <= P, pwm_o is 1 for W count ticks from the wrap to 0 and 0 for the remaining P-W+1 ticks of the period.
- R4: A write to either host compare register leaves the current period unchanged; the value moves into its buffer only at the next wrap to 0 (or at start).
- R5: width_irq_o pulses for one clock after each tick on which the counter takes a value equal to the width buffer (including 0 at a wrap when W is 0).
- R6: wrap_irq_o pulses for one clock after each tick that clears the counter from P to 0; it does not pulse on the tick that reaches P, and it does not pulse on the first tick after start.
- R7: On the first count tick after run goes to 1 the counter goes from all-ones to 0, both buffers load from the host registers, and pwm_o goes to 1 if the loaded width is non-zero.
- R8: half_rate_o starts at 0 and inverts on each wrap tick (each wrap_irq_o pulse); it does not change at start.
- R9: The counter and all outputs hold on clocks where count_tick_i is 0; each count tick advances the waveform by one step.
- R10: One clock after run_i is sampled 0, the counter is parked at all-ones and all four outputs are 0; the next start begins a fresh period from 0.
- R11: A width of 0 keeps pwm_o at 0 for the whole period; a width above P keeps pwm_o at 1 for the whole period.
- R12: Each interrupt output is high for one clock per event and only on the clock after a count tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_i | input | 1 | Timer enable; 0 parks the counter and silences the outputs |
| count_tick_i | input | 1 | Count-tick enable; the counter steps on clocks where it is 1 |
| period_we_i | input | 1 | Write strobe for the host period register |
| period_wdata_i | input | 16 | Data for the host period register |
| width_we_i | input | 1 | Write strobe for the host width register |
| width_wdata_i | input | 16 | Data for the host width register |
| pwm_o | output | 1 | PWM output, 1 = active |
| half_rate_o | output | 1 | Toggles on every wrap |
| wrap_irq_o | output | 1 | One-clock pulse when the counter wraps from the period value to 0 |
| width_irq_o | output | 1 | One-clock pulse when the counter reaches the width value |

## Verification
The assertions take for granted that run_i and count_tick_i are synchronous to clk and stable around its rising edge, and that a write strobe lasts exactly the clocks it is meant to act on. The stimulus drives every input on the falling edge, raises each write strobe for a single clock, and holds run_i low until the internal reset release has completed. Writes are placed at known points in a period so that the buffered value is expected either in the running period or in the next one, never on a guess.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  localparam int unsigned TMR_W_DEF = 16;

  // Compare channel slots; the period slot governs the wrap.
  localparam int unsigned CH_PERIOD = 0;
  localparam int unsigned CH_WIDTH  = 1;
  localparam int unsigned N_CH      = 2;

endpackage

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned TMR_W = TMR_W_DEF,
  parameter int unsigned NCH   = N_CH
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            wr_en,
  input  logic [NCH-1:0][TMR_W-1:0] wr_data,
  input  logic                      load,
  output logic [NCH-1:0][TMR_W-1:0] shadow_q,
  output logic [NCH-1:0][TMR_W-1:0] shadow_nxt
);

  logic [NCH-1:0][TMR_W-1:0] host_q;
  logic [NCH-1:0][TMR_W-1:0] host_nxt;

  for (genvar c = 0; c < NCH; c++) begin : g_ch

    always_comb begin
      host_nxt[c] = host_q[c];
      if (wr_en[c]) begin
        host_nxt[c] = wr_data[c];
      end
    end

    always_comb begin
      shadow_nxt[c] = shadow_q[c];
      if (load) begin
        shadow_nxt[c] = host_q[c];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        host_q[c]   <= '0;
        shadow_q[c] <= '0;
      end else begin
        host_q[c]   <= host_nxt[c];
        shadow_q[c] <= shadow_nxt[c];
      end
    end

    AST_SHADOW_ONLY_AT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(shadow_q[c])); // R4

    AST_SHADOW_TAKES_HOST: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !wr_en[c]) |=> (shadow_q[c] == host_q[c])); // R7

  end : g_ch

endmodule

// File: rtl/pwm_cnt_core.sv
module pwm_cnt_core
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned TMR_W = TMR_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [TMR_W-1:0] period_buf,
  output logic             step,
  output logic             load,
  output logic             wrap,
  output logic [TMR_W-1:0] cnt_nxt
);

  localparam logic [TMR_W-1:0] PARK = '1;
  localparam logic [TMR_W-1:0] ONE  = TMR_W'(1);

  logic [TMR_W-1:0] cnt_q;
  logic             live_q;
  logic             live_nxt;
  logic             at_top;

  always_comb begin
    step   = run && tick;
    at_top = live_q && (cnt_q == period_buf);
    load   = step && (!live_q || at_top);
    wrap   = step && at_top;
  end

  always_comb begin
    cnt_nxt  = cnt_q;
    live_nxt = live_q;
    if (!run) begin
      cnt_nxt  = PARK;
      live_nxt = 1'b0;
    end else if (step) begin
      live_nxt = 1'b1;
      if (load) begin
        cnt_nxt = '0;
      end else begin
        cnt_nxt = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= PARK;
      live_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      live_q <= live_nxt;
    end
  end

  AST_PARKED_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == PARK && !live_q)); // R10

  AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_q)); // R9

  AST_CNT_WITHIN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (cnt_q <= period_buf)); // R2

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !live_q) |=> (cnt_q == '0 && live_q)); // R7

endmodule

// File: rtl/pwm_out_gen.sv
module pwm_out_gen
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned TMR_W = TMR_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             step,
  input  logic             load,
  input  logic             wrap,
  input  logic [TMR_W-1:0] cnt_nxt,
  input  logic [TMR_W-1:0] width_buf,
  input  logic [TMR_W-1:0] width_nxt,
  output logic             pwm_q,
  output logic             half_q,
  output logic             wrap_irq_q,
  output logic             width_irq_q
);

  logic pwm_nxt;
  logic half_nxt;
  logic wrap_irq_nxt;
  logic width_irq_nxt;

  always_comb begin
    pwm_nxt       = pwm_q;
    half_nxt      = half_q;
    wrap_irq_nxt  = 1'b0;
    width_irq_nxt = 1'b0;
    if (!run) begin
      pwm_nxt  = 1'b0;
      half_nxt = 1'b0;
    end else if (step) begin
      width_irq_nxt = (cnt_nxt == width_nxt);
      wrap_irq_nxt  = wrap;
      if (wrap) begin
        half_nxt = !half_q;
      end
      if (load) begin
        pwm_nxt = (width_nxt != '0);
      end else if (cnt_nxt == width_buf) begin
        pwm_nxt = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q       <= 1'b0;
      half_q      <= 1'b0;
      wrap_irq_q  <= 1'b0;
      width_irq_q <= 1'b0;
    end else begin
      pwm_q       <= pwm_nxt;
      half_q      <= half_nxt;
      wrap_irq_q  <= wrap_irq_nxt;
      width_irq_q <= width_irq_nxt;
    end
  end

  AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pwm_q && !half_q && !wrap_irq_q && !width_irq_q)); // R10

  AST_HALF_FLIPS_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_irq_q |-> (half_q != $past(half_q))); // R8

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> (!wrap_irq_q && !width_irq_q)); // R12

  AST_NO_WRAP_IRQ_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !wrap) |=> !wrap_irq_q); // R6

  AST_ZERO_WIDTH_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (load && width_nxt == '0) |=> !pwm_q); // R11

endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned TMR_W = TMR_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             count_tick_i,
  input  logic             period_we_i,
  input  logic [TMR_W-1:0] period_wdata_i,
  input  logic             width_we_i,
  input  logic [TMR_W-1:0] width_wdata_i,
  output logic             pwm_o,
  output logic             half_rate_o,
  output logic             wrap_irq_o,
  output logic             width_irq_o
);

  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = rst_sync_q[1];

  logic [N_CH-1:0]            wr_en;
  logic [N_CH-1:0][TMR_W-1:0] wr_data;
  logic [N_CH-1:0][TMR_W-1:0] shadow_q;
  logic [N_CH-1:0][TMR_W-1:0] shadow_nxt;
  logic                       step;
  logic                       load;
  logic                       wrap;
  logic [TMR_W-1:0]           cnt_nxt;

  always_comb begin
    wr_en              = '0;
    wr_data            = '0;
    wr_en[CH_PERIOD]   = period_we_i;
    wr_data[CH_PERIOD] = period_wdata_i;
    wr_en[CH_WIDTH]    = width_we_i;
    wr_data[CH_WIDTH]  = width_wdata_i;
  end

  pwm_cmp_bank #(.TMR_W(TMR_W), .NCH(N_CH)) u_bank (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .load       (load),
    .shadow_q   (shadow_q),
    .shadow_nxt (shadow_nxt)
  );

  pwm_cnt_core #(.TMR_W(TMR_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .run        (run_i),
    .tick       (count_tick_i),
    .period_buf (shadow_q[CH_PERIOD]),
    .step       (step),
    .load       (load),
    .wrap       (wrap),
    .cnt_nxt    (cnt_nxt)
  );

  pwm_out_gen #(.TMR_W(TMR_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .run         (run_i),
    .step        (step),
    .load        (load),
    .wrap        (wrap),
    .cnt_nxt     (cnt_nxt),
    .width_buf   (shadow_q[CH_WIDTH]),
    .width_nxt   (shadow_nxt[CH_WIDTH]),
    .pwm_q       (pwm_o),
    .half_q      (half_rate_o),
    .wrap_irq_q  (wrap_irq_o),
    .width_irq_q (width_irq_o)
  );

endmodule

// File: tb/pwm_dbuf_timer_bench.sv
`timescale 1ns/1ps
module pwm_dbuf_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run_i = 1'b0;
  logic        count_tick_i = 1'b1;
  logic        period_we_i = 1'b0;
  logic [15:0] period_wdata_i = '0;
  logic        width_we_i = 1'b0;
  logic [15:0] width_wdata_i = '0;
  logic        pwm_o, half_rate_o, wrap_irq_o, width_irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit gated  = 1'b0;
  int phase  = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  pwm_dbuf_timer u_pwm_dbuf_timer (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_i          (run_i),
    .count_tick_i   (count_tick_i),
    .period_we_i    (period_we_i),
    .period_wdata_i (period_wdata_i),
    .width_we_i     (width_we_i),
    .width_wdata_i  (width_wdata_i),
    .pwm_o          (pwm_o),
    .half_rate_o    (half_rate_o),
    .wrap_irq_o     (wrap_irq_o),
    .width_irq_o    (width_irq_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Count-tick pattern: every clock, or one clock in three.
  always @(negedge clk) begin
    if (gated) begin
      phase = (phase + 1) % 3;
      count_tick_i = (phase == 0);
    end else begin
      count_tick_i = 1'b1;
    end
  end

  // Behavioural reference model, stepped on each rising edge.
  int m_cnt, m_pbuf, m_wbuf, m_phost, m_whost;
  bit m_live, m_pwm, m_half, m_wirq, m_dirq;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 65535; m_live = 0; m_pbuf = 0; m_wbuf = 0;
      m_phost = 0; m_whost = 0; m_pwm = 0; m_half = 0; m_wirq = 0; m_dirq = 0;
    end else begin
      m_wirq = 0;
      m_dirq = 0;
      if (!run_i) begin
        m_cnt = 65535; m_live = 0; m_pwm = 0; m_half = 0;
      end else if (count_tick_i) begin
        if (!m_live || m_cnt == m_pbuf) begin
          if (m_live) begin
            m_wirq = 1;
            m_half = !m_half;
          end
          m_live = 1;
          m_pbuf = m_phost;
          m_wbuf = m_whost;
          m_cnt  = 0;
          m_pwm  = (m_wbuf != 0);
        end else begin
          m_cnt = m_cnt + 1;
          if (m_cnt == m_wbuf) m_pwm = 0;
        end
        m_dirq = (m_cnt == m_wbuf);
      end
      if (period_we_i) m_phost = period_wdata_i;
      if (width_we_i)  m_whost = width_wdata_i;
    end
  end

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (!done) begin
      chk("R3 pwm_o vs model", pwm_o, m_pwm);
      chk("R8 half_rate_o vs model", half_rate_o, m_half);
      chk("R6 wrap_irq_o vs model", wrap_irq_o, m_wirq);
      chk("R5 width_irq_o vs model", width_irq_o, m_dirq);
    end
  end

  task automatic wait_wrap();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (wrap_irq_o) return;
    end
    chk("R6 wrap seen", 0, 1);
  endtask

  // Called on a negedge where wrap_irq_o is 1; runs to the next wrap pulse.
  task automatic measure(input bit do_wr, input int wval,
                         output int len, output int hi, output int dirqs,
                         output int half_flip);
    int h0;
    h0 = half_rate_o;
    len = 0; hi = 0; dirqs = 0;
    for (int i = 0; i < 2000; i++) begin
      if (pwm_o) hi++;
      if (width_irq_o) dirqs++;
      len++;
      if (do_wr && i == 0) begin
        width_we_i = 1'b1;
        width_wdata_i = 16'(wval);
      end else begin
        width_we_i = 1'b0;
      end
      @(negedge clk);
      if (wrap_irq_o) break;
    end
    half_flip = (half_rate_o != h0);
  endtask

  int len, hi, dq, hf;

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pwm_o after reset", pwm_o, 0);
    chk("R1 half_rate_o after reset", half_rate_o, 0);
    chk("R1 irqs after reset", wrap_irq_o | width_irq_o, 0);

    // Program P=9, W=3 while stopped, then start.
    period_we_i = 1; period_wdata_i = 16'd9;
    width_we_i = 1;  width_wdata_i = 16'd3;
    @(negedge clk);
    period_we_i = 0; width_we_i = 0;
    run_i = 1;
    @(negedge clk);
    chk("R7 pwm_o active on first tick", pwm_o, 1);
    chk("R6 no wrap irq at start", wrap_irq_o, 0);
    chk("R8 half_rate_o unchanged at start", half_rate_o, 0);

    wait_wrap();
    measure(0, 0, len, hi, dq, hf);
    chk("R2 period length P+1", len, 10);
    chk("R3 active ticks W", hi, 3);
    chk("R12 one width irq per period", dq, 1);
    chk("R8 half_rate_o flipped on wrap", hf, 1);

    measure(1, 7, len, hi, dq, hf);
    chk("R4 width write not in running period", hi, 3);
    measure(0, 0, len, hi, dq, hf);
    chk("R4 width write at next period", hi, 7);

    measure(1, 0, len, hi, dq, hf);
    measure(0, 0, len, hi, dq, hf);
    chk("R11 zero width stays inactive", hi, 0);
    chk("R5 width irq at wrap for W=0", dq, 1);

    measure(1, 12, len, hi, dq, hf);
    measure(0, 0, len, hi, dq, hf);
    chk("R11 width above period stays active", hi, 10);
    chk("R5 no width irq when W>P", dq, 0);

    // One tick in three.
    measure(1, 3, len, hi, dq, hf);
    gated = 1'b1;
    wait_wrap();
    measure(0, 0, len, hi, dq, hf);
    chk("R9 gated period in clocks", len, 30);
    chk("R9 gated active clocks", hi, 9);
    chk("R12 gated single width irq", dq, 1);
    gated = 1'b0;

    // Stop, reprogram, restart.
    run_i = 0;
    @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      chk("R10 outputs quiet when stopped",
          pwm_o | half_rate_o | wrap_irq_o | width_irq_o, 0);
      @(negedge clk);
    end
    period_we_i = 1; period_wdata_i = 16'd4;
    width_we_i = 1;  width_wdata_i = 16'd2;
    @(negedge clk);
    period_we_i = 0; width_we_i = 0;
    run_i = 1;
    @(negedge clk);
    chk("R10 restart pwm_o active", pwm_o, 1);
    chk("R7 restart no wrap irq", wrap_irq_o, 0);
    wait_wrap();
    measure(0, 0, len, hi, dq, hf);
    chk("R7 restart period uses new P", len, 5);
    chk("R7 restart width uses new W", hi, 2);

    run_i = 0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule